// File: doc/BRIEF.md
# Speculative Instruction Retirement Queue

This block keeps the program order of instructions that a dynamically scheduled core has issued but not yet retired. Each issued instruction takes the slot at the tail of a circular queue. The index of that slot becomes the rename tag under which the instruction's result is later delivered. An execution unit that finishes writes its result and its status flags into the slot named by its tag. A register mapping table records, for every architectural register, the tag of the most recent instruction that will write it. Later instructions can therefore find their operands either in the register file or in the queue.

Retirement is strictly in order from the head slot, and only once that slot holds a result. A retiring register operation produces a register-file write, and a retiring store produces a memory write. A retiring branch that was correctly predicted produces neither. A branch recorded as mispredicted, or any instruction recorded as having raised an exception, is handled only when it reaches the head. At that point every younger slot is discarded and all register mappings are cleared. Reservation stations and execution units sit outside the block. The issue side presents a reservation-station-free flag, and the execution side presents one completion port.

Top module: `rob_top`

## Requirements
- R1: After a synchronous reset the queue is empty, `iss_ready` is 1, `iss_tag` is 0, no source is reported pending, and `cmt_reg_we`, `cmt_mem_we`, `flush_o` and `exc_o` are 0.
- R2: An instruction is accepted at a clock edge when `iss_valid`, `iss_rs_free` and `iss_ready` are all 1. `iss_tag` always shows the tail slot index, which advances by one per accepted instruction, modulo DEPTH. The kind encoding is 0 = register operation, 1 = store, 2 = branch.
- R3: `iss_ready` is 0 while DEPTH instructions are in flight. No instruction is accepted while `iss_rs_free` is 0.
- R4: A completion (`cpl_valid`) writes the value, the exception flag and the mispredict flag into slot `cpl_tag` and marks it ready. From the next cycle a source lookup that maps to that slot reports ready with that value.
- R5: Source lookup port i takes a register number in bits [i*REG_W +: REG_W] of `src_reg`. It reports, combinationally from current state, whether the register has an in-flight producer, that producer's tag, its ready flag and its value. The latest accepted writer wins.
- R6: Only the head slot retires, and only once it is ready. A ready younger slot waits. The effects of a retirement appear on the registered outputs in the cycle after the retiring clock edge.
- R7: A retiring register operation pulses `cmt_reg_we` with `cmt_dest` (register number in the low REG_W bits) and `cmt_data`. A retiring store pulses `cmt_mem_we` with the address in `cmt_dest` and the store data in `cmt_data`. A retiring correctly predicted branch pulses neither.
- R8: On retirement of a register operation, the mapping of its destination is cleared only if it still holds the retiring slot's tag. A newer producer keeps its mapping.
- R9: When a ready mispredicted branch is at the head, it retires and `flush_o` pulses. All younger slots are discarded, all mappings clear, the queue becomes empty, and `iss_tag` becomes the old head index plus one.
- R10: When a ready slot carrying an exception is at the head, `exc_o` and `flush_o` pulse with `exc_tag_o` equal to that slot. No register or memory write occurs, and that slot and every younger one are discarded as in R9.
- R11: In a cycle where the head triggers a flush, `iss_ready` is 0 and no instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_rs_free | input | 1 | A reservation station is free for it |
| iss_kind | input | 2 | 0 register op, 1 store, 2 branch |
| iss_dest | input | DEST_W | Register number (low bits) or store address |
| iss_ready | output | 1 | A slot is free and no flush is under way |
| iss_tag | output | TAG_W | Tag given to the next accepted instruction |
| cpl_valid | input | 1 | A result is delivered |
| cpl_tag | input | TAG_W | Slot receiving the result |
| cpl_value | input | DATA_W | Result value or store data |
| cpl_exc | input | 1 | The instruction raised an exception |
| cpl_mispredict | input | 1 | The branch was mispredicted |
| src_reg | input | NUM_SRC*REG_W | Registers to look up |
| src_pending | output | NUM_SRC | Register has an in-flight producer |
| src_tag | output | NUM_SRC*TAG_W | Tag of that producer |
| src_ready | output | NUM_SRC | Producer has its result |
| src_value | output | NUM_SRC*DATA_W | Producer's result |
| cmt_reg_we | output | 1 | Register-file write from retirement |
| cmt_mem_we | output | 1 | Memory write from a retiring store |
| cmt_dest | output | DEST_W | Write register or address |
| cmt_data | output | DATA_W | Write data |
| flush_o | output | 1 | Younger work discarded this cycle |
| exc_o | output | 1 | Exception signalled at the head |
| exc_tag_o | output | TAG_W | Slot that raised the exception |

## Verification
Three groups of results fall due at different times. `iss_ready`, `iss_tag` and the lookup outputs depend only on state, so they are due as soon as the preceding edge has settled. The write, flush and exception pulses are registered, so they are due exactly one cycle after the edge at which the head retires. A completion becomes visible to lookups one edge after it is driven, and it can cause a retirement one edge after that. The bench drives its inputs on the falling edge. It checks the state-driven outputs there, before updating its reference model, and checks the lookups 1 ns later. It compares the registered pulses one falling edge after the model's step, so every comparison falls in the cycle in which that result is due.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } op_kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= nxt(head);
      tail  <= nxt(head);
      count <= '0;
    end else begin
      if (retire) head <= nxt(head);
      if (alloc)  tail <= nxt(tail);
      count <= count + CNT_W'(alloc) - CNT_W'(retire);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst) alloc |-> !full);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH));
  a_r6_no_retire_empty: assert property (@(posedge clk) disable iff (rst) retire |-> !empty);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst) flush |=> empty);
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DEST_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 2,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  op_kind_e                  alloc_kind,
  input  logic [DEST_W-1:0]         alloc_dest,
  input  logic                      cpl_valid,
  input  logic [TAG_W-1:0]          cpl_tag,
  input  logic [DATA_W-1:0]         cpl_value,
  input  logic                      cpl_exc,
  input  logic                      cpl_mis,
  input  logic [TAG_W-1:0]          head_tag,
  output op_kind_e                  head_kind,
  output logic [DEST_W-1:0]         head_dest,
  output logic [DATA_W-1:0]         head_value,
  output logic                      head_ready,
  output logic                      head_exc,
  output logic                      head_mis,
  input  logic [NUM_SRC*TAG_W-1:0]  rd_tag,
  output logic [NUM_SRC-1:0]        rd_ready,
  output logic [NUM_SRC*DATA_W-1:0] rd_value
);
  op_kind_e          kind_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [DEPTH-1:0]  rdy_q, exc_q, mis_q;

  // value storage: one write port, no reset
  always_ff @(posedge clk) begin
    if (cpl_valid) val_q[cpl_tag] <= cpl_value;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      kind_q[alloc_tag] <= alloc_kind;
      dest_q[alloc_tag] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= '0;
      exc_q <= '0;
      mis_q <= '0;
    end else begin
      if (cpl_valid) begin
        rdy_q[cpl_tag] <= 1'b1;
        exc_q[cpl_tag] <= cpl_exc;
        mis_q[cpl_tag] <= cpl_mis;
      end
      if (alloc) begin
        rdy_q[alloc_tag] <= 1'b0;
        exc_q[alloc_tag] <= 1'b0;
        mis_q[alloc_tag] <= 1'b0;
      end
    end
  end

  assign head_kind  = kind_q[head_tag];
  assign head_dest  = dest_q[head_tag];
  assign head_value = val_q[head_tag];
  assign head_ready = rdy_q[head_tag];
  assign head_exc   = exc_q[head_tag];
  assign head_mis   = mis_q[head_tag];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_rd
    logic [TAG_W-1:0] t;
    assign t = rd_tag[i*TAG_W +: TAG_W];
    assign rd_ready[i] = rdy_q[t];
    assign rd_value[i*DATA_W +: DATA_W] = val_q[t];
  end

  a_r4_ready_after_cpl: assert property (@(posedge clk) disable iff (rst)
    (cpl_valid && !(alloc && alloc_tag == cpl_tag)) |=> rdy_q[$past(cpl_tag)]);
  a_r2_alloc_clears: assert property (@(posedge clk) disable iff (rst)
    alloc |=> !rdy_q[$past(alloc_tag)]);
endmodule

// File: rtl/rob_map.sv
module rob_map #(
  parameter int NUM_REGS = 16,
  parameter int DEPTH    = 8,
  parameter int NUM_SRC  = 2,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int TAG_W   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     set_en,
  input  logic [REG_W-1:0]         set_reg,
  input  logic [TAG_W-1:0]         set_tag,
  input  logic                     clr_en,
  input  logic [REG_W-1:0]         clr_reg,
  input  logic [TAG_W-1:0]         clr_tag,
  input  logic [NUM_SRC*REG_W-1:0] src_reg,
  output logic [NUM_SRC-1:0]       src_pend,
  output logic [NUM_SRC*TAG_W-1:0] src_tag
);
  logic [NUM_REGS-1:0] valid_q;
  logic [TAG_W-1:0]    tag_q [NUM_REGS];
  logic                clr_hit;

  assign clr_hit = clr_en && valid_q[clr_reg] && (tag_q[clr_reg] == clr_tag)
                   && !(set_en && set_reg == clr_reg);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else begin
      if (clr_hit) valid_q[clr_reg] <= 1'b0;
      if (set_en)  valid_q[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) tag_q[set_reg] <= set_tag;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [REG_W-1:0] r;
    assign r = src_reg[i*REG_W +: REG_W];
    assign src_pend[i] = valid_q[r];
    assign src_tag[i*TAG_W +: TAG_W] = tag_q[r];
  end

  a_r9_map_cleared: assert property (@(posedge clk) disable iff (rst)
    flush |=> ($countones(valid_q) == 0));
  a_r5_set_visible: assert property (@(posedge clk) disable iff (rst)
    (set_en && !flush) |=> (valid_q[$past(set_reg)] && tag_q[$past(set_reg)] == $past(set_tag)));
  a_r8_keep_newer: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !flush && !set_en && valid_q[clr_reg] && tag_q[clr_reg] != clr_tag)
    |=> valid_q[$past(clr_reg)]);
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int DEST_W   = 16,
  parameter int NUM_SRC  = 2,
  localparam int TAG_W   = $clog2(DEPTH),
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iss_valid,
  input  logic                      iss_rs_free,
  input  logic [1:0]                iss_kind,
  input  logic [DEST_W-1:0]         iss_dest,
  output logic                      iss_ready,
  output logic [TAG_W-1:0]          iss_tag,
  input  logic                      cpl_valid,
  input  logic [TAG_W-1:0]          cpl_tag,
  input  logic [DATA_W-1:0]         cpl_value,
  input  logic                      cpl_exc,
  input  logic                      cpl_mispredict,
  input  logic [NUM_SRC*REG_W-1:0]  src_reg,
  output logic [NUM_SRC-1:0]        src_pending,
  output logic [NUM_SRC*TAG_W-1:0]  src_tag,
  output logic [NUM_SRC-1:0]        src_ready,
  output logic [NUM_SRC*DATA_W-1:0] src_value,
  output logic                      cmt_reg_we,
  output logic                      cmt_mem_we,
  output logic [DEST_W-1:0]         cmt_dest,
  output logic [DATA_W-1:0]         cmt_data,
  output logic                      flush_o,
  output logic                      exc_o,
  output logic [TAG_W-1:0]          exc_tag_o
);
  logic [TAG_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic              full, empty;
  op_kind_e          head_kind, new_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic              head_ready, head_exc, head_mis;
  logic              head_live, flush_now, commit_now, alloc;

  assign new_kind   = op_kind_e'(iss_kind);
  assign head_live  = !empty && head_ready;
  assign flush_now  = head_live && (head_exc || (head_kind == KIND_BRANCH && head_mis));
  assign commit_now = head_live && !head_exc;
  assign iss_ready  = !full && !flush_now;
  assign iss_tag    = tail;
  assign alloc      = iss_valid && iss_rs_free && iss_ready;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .alloc(alloc), .retire(head_live), .flush(flush_now),
    .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
  );

  rob_entries #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_entries (
    .clk(clk), .rst(rst),
    .alloc(alloc), .alloc_tag(tail), .alloc_kind(new_kind), .alloc_dest(iss_dest),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_value(cpl_value),
    .cpl_exc(cpl_exc), .cpl_mis(cpl_mispredict),
    .head_tag(head), .head_kind(head_kind), .head_dest(head_dest), .head_value(head_value),
    .head_ready(head_ready), .head_exc(head_exc), .head_mis(head_mis),
    .rd_tag(src_tag), .rd_ready(src_ready), .rd_value(src_value)
  );

  rob_map #(.NUM_REGS(NUM_REGS), .DEPTH(DEPTH), .NUM_SRC(NUM_SRC)) u_map (
    .clk(clk), .rst(rst), .flush(flush_now),
    .set_en(alloc && new_kind == KIND_REG), .set_reg(iss_dest[REG_W-1:0]), .set_tag(tail),
    .clr_en(commit_now && head_kind == KIND_REG), .clr_reg(head_dest[REG_W-1:0]), .clr_tag(head),
    .src_reg(src_reg), .src_pend(src_pending), .src_tag(src_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmt_reg_we <= 1'b0;
      cmt_mem_we <= 1'b0;
      cmt_dest   <= '0;
      cmt_data   <= '0;
      flush_o    <= 1'b0;
      exc_o      <= 1'b0;
      exc_tag_o  <= '0;
    end else begin
      cmt_reg_we <= commit_now && head_kind == KIND_REG;
      cmt_mem_we <= commit_now && head_kind == KIND_STORE;
      cmt_dest   <= head_dest;
      cmt_data   <= head_value;
      flush_o    <= flush_now;
      exc_o      <= head_live && head_exc;
      exc_tag_o  <= head;
    end
  end

  a_r10_exc_no_write: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> (!cmt_reg_we && !cmt_mem_we));
  a_r11_no_issue_on_flush: assert property (@(posedge clk) disable iff (rst)
    flush_now |-> !iss_ready);
  a_r7_single_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmt_reg_we, cmt_mem_we}));
  a_r6_commit_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (cmt_reg_we || cmt_mem_we) |-> $past(head_ready && !empty));
  a_r10_exc_flushes: assert property (@(posedge clk) disable iff (rst)
    exc_o |-> flush_o);
endmodule

// File: tb/tb_rob_top.sv
`timescale 1ns/1ps
module tb_rob_top;
  localparam int D = 8, NR = 16, DW = 32, DSTW = 16, NS = 2, TW = 3, RW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic iss_valid = 0, iss_rs_free = 0;
  logic [1:0] iss_kind = 0;
  logic [DSTW-1:0] iss_dest = 0;
  logic iss_ready;
  logic [TW-1:0] iss_tag;
  logic cpl_valid = 0, cpl_exc = 0, cpl_mispredict = 0;
  logic [TW-1:0] cpl_tag = 0;
  logic [DW-1:0] cpl_value = 0;
  logic [NS*RW-1:0] src_reg = 0;
  logic [NS-1:0] src_pending, src_ready;
  logic [NS*TW-1:0] src_tag;
  logic [NS*DW-1:0] src_value;
  logic cmt_reg_we, cmt_mem_we, flush_o, exc_o;
  logic [DSTW-1:0] cmt_dest;
  logic [DW-1:0] cmt_data;
  logic [TW-1:0] exc_tag_o;

  rob_top #(.DEPTH(D), .NUM_REGS(NR), .DATA_W(DW), .DEST_W(DSTW), .NUM_SRC(NS)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_rs_free(iss_rs_free),
    .iss_kind(iss_kind), .iss_dest(iss_dest), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_value(cpl_value), .cpl_exc(cpl_exc),
    .cpl_mispredict(cpl_mispredict), .src_reg(src_reg), .src_pending(src_pending),
    .src_tag(src_tag), .src_ready(src_ready), .src_value(src_value),
    .cmt_reg_we(cmt_reg_we), .cmt_mem_we(cmt_mem_we), .cmt_dest(cmt_dest),
    .cmt_data(cmt_data), .flush_o(flush_o), .exc_o(exc_o), .exc_tag_o(exc_tag_o)
  );

  always #2 clk = ~clk;

  int checks = 0, failures = 0;

  // reference model state
  int m_head = 0, m_tail = 0, m_count = 0;
  int m_kind [D];
  logic [DSTW-1:0] m_dest [D];
  logic [DW-1:0] m_val [D];
  bit m_rdy [D], m_exc [D], m_mis [D];
  bit m_mapv [NR];
  int m_mapt [NR];
  bit e_reg_we = 0, e_mem_we = 0, e_flush = 0, e_exc = 0;
  logic [DSTW-1:0] e_dest = 0;
  logic [DW-1:0] e_data = 0;
  int e_exc_tag = 0;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int nxt(int p);
    return (p == D - 1) ? 0 : p + 1;
  endfunction

  task automatic idle();
    iss_valid = 0; iss_rs_free = 1; cpl_valid = 0; cpl_exc = 0; cpl_mispredict = 0;
  endtask

  task automatic issue(int kind, int dest);
    iss_valid = 1; iss_rs_free = 1; iss_kind = 2'(kind); iss_dest = DSTW'(dest);
  endtask

  task automatic complete(int tag, logic [DW-1:0] v, bit ex, bit mis);
    cpl_valid = 1; cpl_tag = TW'(tag); cpl_value = v; cpl_exc = ex; cpl_mispredict = mis;
  endtask

  // one cycle: called just after a falling edge with inputs already set
  task automatic cycle();
    bit hr, fl, cm, acc;
    int h, r;
    // R6/R7/R9/R10: registered outputs from the last edge
    chk("R7", "cmt_reg_we", cmt_reg_we, e_reg_we);
    chk("R7", "cmt_mem_we", cmt_mem_we, e_mem_we);
    if (e_reg_we || e_mem_we) begin
      chk("R7", "cmt_dest", cmt_dest, e_dest);
      chk("R6", "cmt_data", cmt_data, e_data);
    end
    chk("R9", "flush_o", flush_o, e_flush);
    chk("R10", "exc_o", exc_o, e_exc);
    if (e_exc) chk("R10", "exc_tag_o", exc_tag_o, e_exc_tag);
    h  = m_head;
    hr = (m_count > 0) && m_rdy[h];
    fl = hr && (m_exc[h] || (m_kind[h] == 2 && m_mis[h]));
    cm = hr && !m_exc[h];
    chk("R3", "iss_ready", iss_ready, (m_count < D) && !fl);
    chk("R2", "iss_tag", iss_tag, m_tail);
    #1;
    for (int i = 0; i < NS; i++) begin
      r = int'(src_reg[i*RW +: RW]);
      chk("R5", "src_pending", src_pending[i], m_mapv[r]);
      if (m_mapv[r]) begin
        chk("R5", "src_tag", src_tag[i*TW +: TW], m_mapt[r]);
        chk("R4", "src_ready", src_ready[i], m_rdy[m_mapt[r]]);
        if (m_rdy[m_mapt[r]]) chk("R4", "src_value", src_value[i*DW +: DW], m_val[m_mapt[r]]);
      end
    end
    acc = iss_valid && iss_rs_free && (m_count < D) && !fl;
    e_reg_we = cm && m_kind[h] == 0;
    e_mem_we = cm && m_kind[h] == 1;
    e_dest = m_dest[h]; e_data = m_val[h];
    e_flush = fl; e_exc = hr && m_exc[h]; e_exc_tag = h;
    if (cpl_valid) begin
      m_val[cpl_tag] = cpl_value; m_rdy[cpl_tag] = 1;
      m_exc[cpl_tag] = cpl_exc; m_mis[cpl_tag] = cpl_mispredict;
    end
    if (acc) begin
      m_kind[m_tail] = int'(iss_kind); m_dest[m_tail] = iss_dest;
      m_rdy[m_tail] = 0; m_exc[m_tail] = 0; m_mis[m_tail] = 0;
    end
    if (fl) begin
      for (int k = 0; k < NR; k++) m_mapv[k] = 0;
      m_head = nxt(h); m_tail = m_head; m_count = 0;
    end else begin
      if (cm && m_kind[h] == 0) begin
        r = int'(m_dest[h][RW-1:0]);
        if (m_mapv[r] && m_mapt[r] == h) m_mapv[r] = 0;
      end
      if (acc && iss_kind == 2'd0) begin
        m_mapv[int'(iss_dest[RW-1:0])] = 1; m_mapt[int'(iss_dest[RW-1:0])] = m_tail;
      end
      if (hr) begin m_head = nxt(h); m_count--; end
      if (acc) begin m_tail = nxt(m_tail); m_count++; end
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL all watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    for (int i = 0; i < D; i++) begin
      m_kind[i] = 0; m_dest[i] = 0; m_val[i] = 0; m_rdy[i] = 0; m_exc[i] = 0; m_mis[i] = 0;
    end
    for (int i = 0; i < NR; i++) begin m_mapv[i] = 0; m_mapt[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    // R1: reset state
    src_reg = {4'd3, 4'd1};
    #1;
    chk("R1", "iss_ready", iss_ready, 1);
    chk("R1", "iss_tag", iss_tag, 0);
    chk("R1", "src_pending", src_pending, 0);
    chk("R1", "cmt_reg_we", cmt_reg_we, 0);
    chk("R1", "flush_o", flush_o, 0);
    @(negedge clk);

    // R3: no reservation station, no issue
    issue(0, 1); iss_rs_free = 0; cycle();
    chk("R3", "tag_unchanged", iss_tag, 0);
    // R2/R3: fill the queue with register ops to r1..r8
    for (int i = 0; i < D; i++) begin issue(0, i + 1); src_reg = {4'(i), 4'(i + 1)}; cycle(); end
    issue(0, 9); cycle();
    chk("R3", "full_ready", iss_ready, 0);
    // R4/R6: complete a younger slot first, head stays
    idle(); complete(3, 32'hA5A5_0003, 0, 0); src_reg = {4'd4, 4'd4}; cycle();
    idle(); cycle(); cycle();
    for (int i = 0; i < D; i++) begin
      if (i != 3) begin idle(); complete(i, 32'h1000 + i, 0, 0); src_reg = {4'(i + 1), 4'd4}; cycle(); end
    end
    idle(); for (int i = 0; i < D + 2; i++) cycle();
    chk("R6", "drained_tag", iss_tag, 0);

    // R8: two writers of r5, first retires, mapping stays with second
    issue(0, 5); cycle();
    issue(0, 5); cycle();
    idle(); complete(0, 32'h55, 0, 0); src_reg = {4'd5, 4'd5}; cycle();
    idle(); cycle(); cycle();
    chk("R8", "still_pending", src_pending[0], 1);
    chk("R8", "newer_tag", src_tag[TW-1:0], 1);
    idle(); complete(1, 32'h66, 0, 0); cycle(); cycle(); cycle();

    // R7/R9: store, good branch, mispredicted branch, then younger work
    issue(1, 16'hBEEF); cycle();
    issue(2, 0); cycle();
    issue(2, 0); cycle();
    issue(0, 7); cycle();
    issue(1, 16'h1234); cycle();
    idle(); complete(2, 32'hD00D, 0, 0); cycle();
    complete(3, 0, 0, 0); cycle();
    complete(5, 32'h77, 0, 0); cycle();
    complete(4, 0, 0, 1); src_reg = {4'd7, 4'd7}; cycle();
    idle(); for (int i = 0; i < 4; i++) cycle();
    chk("R9", "empty_after_flush", iss_ready, 1);
    chk("R9", "map_clear", src_pending, 0);

    // R10/R11: exception at the head with younger work behind it
    issue(0, 2); cycle();
    issue(1, 16'h40); cycle();
    idle(); complete(m_head, 32'hEE, 1, 0); src_reg = {4'd2, 4'd2}; cycle();
    issue(0, 3); cycle();  // R11: flush cycle, not accepted
    idle(); for (int i = 0; i < 3; i++) cycle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      iss_valid = ($urandom % 4) != 0;
      iss_rs_free = ($urandom % 4) != 0;
      iss_kind = 2'($urandom % 3);
      iss_dest = DSTW'($urandom);
      src_reg = NS*RW'($urandom);
      cpl_valid = 0; cpl_exc = 0; cpl_mispredict = 0;
      if (m_count > 0 && ($urandom % 2) == 0) begin
        int t;
        t = (m_head + int'($urandom % m_count)) % D;
        if (!m_rdy[t]) complete(t, $urandom, ($urandom % 24) == 0,
                                (m_kind[t] == 2) && (($urandom % 3) == 0));
      end
      cycle();
    end
    // drain
    idle();
    for (int n = 0; n < 40 && m_count > 0; n++) begin
      idle();
      if (!m_rdy[m_head]) complete(m_head, 32'hC0DE, 0, 0);
      cycle();
    end
    idle(); cycle(); cycle();
    chk("R6", "final_empty", iss_ready, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule